// File: doc/BRIEF.md
# Atomic ALU Pipeline Allocator

This block admits atomic operations into a small set of identical, fixed-latency ALU pipelines inside a cache and hands them back as completions. Requests arrive on several parallel lanes. Lane 0 is the oldest and higher lanes are progressively younger. Each request carries a cache-line address and a tag. The pipelines carry only the address and the tag. The arithmetic of the atomic and the line data are handled elsewhere.

A pipeline accepts a new operation every cycle. However, a line that is still being worked on in any pipeline may not enter again until that operation leaves its last stage. Operations that finish in the same cycle are placed into a completion queue in pipeline-index order and leave it one per cycle. The completion port has no backpressure. For that reason, admission is limited by a credit count that covers the queue and everything in flight. Completions come out on a separate path and take the extra pipeline latency, so they are not ordered against the cache's ordinary responses.

Top module: `atomic_pipe_alloc`

## Requirements
- R1: After reset, no completion is presented. With no lanes valid, every ready bit is 1. With all lanes valid on distinct, idle lines, exactly the lowest NUM_PIPES lanes are ready.
- R2: At most NUM_PIPES requests are accepted per cycle. The accepted lane that is k-th in lane order goes to pipeline k, so the lowest-numbered free pipeline is used first.
- R3: A lane whose address equals that of a lower lane accepted in the same cycle is not ready.
- R4: Acceptance is in lane order: a lane is not ready while any lower lane is valid and not ready.
- R5: A line accepted at clock edge e holds ready low for any lane carrying that line until edge e+PIPE_LAT. A request for that line can be accepted again at edge e+PIPE_LAT.
- R6: An operation accepted at edge e is presented on the completion port right after edge e+PIPE_LAT if no earlier completion is still waiting. Otherwise it is presented in the first following cycle in which none is waiting. Each completion is presented for exactly one cycle.
- R7: Completions carry the accepted address and tag. They leave in order of acceptance edge, and in pipeline-index order (which is also lane order) within one edge.
- R8: Let the outstanding count be the operations accepted and not yet presented, plus the one being presented now. A lane is ready only if the outstanding count plus the lower lanes accepted in the same cycle is below CPLQ_DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | NUM_LANES | Per-lane request valid, lane 0 oldest |
| req_ready_o | output | NUM_LANES | Per-lane acceptance; a transfer happens where valid and ready are both high |
| req_addr_i | input | NUM_LANES*ADDR_W | Per-lane line address, lane k at bits k*ADDR_W upward |
| req_tag_i | input | NUM_LANES*TAG_W | Per-lane tag, lane k at bits k*TAG_W upward |
| cpl_valid_o | output | 1 | Completion present this cycle |
| cpl_addr_o | output | ADDR_W | Line address of the completion |
| cpl_tag_o | output | TAG_W | Tag of the completion |

## Verification
Ready is combinational from the lane inputs and registered state. It is compared one time unit after the inputs change at the falling edge, against a bench model built from R2 to R5 and R8. A completion for an operation accepted at edge e is due at the falling edge that follows edge e+PIPE_LAT. If completions are queued ahead of it, it is due one falling edge after the previous completion instead. The bench keeps accepted operations in a queue stamped with their acceptance edge and checks the completion valid, address and tag at every falling edge. Directed cases measure the exact re-accept interval of one line and the idle-path latency.

// File: rtl/apa_pkg.sv
package apa_pkg;
  localparam int unsigned DEF_LANES  = 3;
  localparam int unsigned DEF_PIPES  = 2;
  localparam int unsigned DEF_LAT    = 4;
  localparam int unsigned DEF_ADDR_W = 12;
  localparam int unsigned DEF_TAG_W  = 6;
  localparam int unsigned DEF_DEPTH  = 8;

  function automatic int unsigned ring_idx(input int unsigned base, input int unsigned off,
                                           input int unsigned depth);
    return (base + off) % depth;
  endfunction
endpackage

// File: rtl/apa_pipe.sv
module apa_pipe #(
  parameter int unsigned LAT    = 4,
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned TAG_W  = 6,
  parameter int unsigned LANES  = 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    in_vld_i,
  input  logic [ADDR_W-1:0]       in_addr_i,
  input  logic [TAG_W-1:0]        in_tag_i,
  input  logic [LANES*ADDR_W-1:0] probe_addr_i,
  output logic [LANES-1:0]        probe_hit_o,
  output logic [LAT-1:0]          stage_vld_o,
  output logic                    ret_vld_o,
  output logic [ADDR_W-1:0]       ret_addr_o,
  output logic [TAG_W-1:0]        ret_tag_o
);
  logic [LAT-1:0]    vld_q;
  logic [ADDR_W-1:0] addr_q [LAT];
  logic [TAG_W-1:0]  tag_q  [LAT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
    end else begin
      vld_q[0] <= in_vld_i;
      for (int i = 1; i < LAT; i++) vld_q[i] <= vld_q[i-1];
    end
  end

  always_ff @(posedge clk_i) begin
    addr_q[0] <= in_addr_i;
    tag_q[0]  <= in_tag_i;
    for (int i = 1; i < LAT; i++) begin
      addr_q[i] <= addr_q[i-1];
      tag_q[i]  <= tag_q[i-1];
    end
  end

  // last stage retires this edge, so it does not block re-entry
  if (LAT > 1) begin : g_probe
    always_comb begin
      probe_hit_o = '0;
      for (int k = 0; k < LANES; k++)
        for (int i = 0; i < LAT - 1; i++)
          if (vld_q[i] && addr_q[i] == probe_addr_i[k*ADDR_W +: ADDR_W]) probe_hit_o[k] = 1'b1;
    end
  end else begin : g_noprobe
    assign probe_hit_o = '0;
  end

  assign stage_vld_o = vld_q;
  assign ret_vld_o   = vld_q[LAT-1];
  assign ret_addr_o  = addr_q[LAT-1];
  assign ret_tag_o   = tag_q[LAT-1];
endmodule

// File: rtl/apa_issue.sv
module apa_issue #(
  parameter int unsigned LANES  = 3,
  parameter int unsigned PIPES  = 2,
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned TAG_W  = 6,
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned CNT_W  = 4
) (
  input  logic [LANES-1:0]        req_valid_i,
  input  logic [LANES*ADDR_W-1:0] req_addr_i,
  input  logic [LANES*TAG_W-1:0]  req_tag_i,
  input  logic [LANES-1:0]        busy_hit_i,
  input  logic [CNT_W-1:0]        outst_i,
  output logic [LANES-1:0]        req_ready_o,
  output logic [PIPES-1:0]        pipe_vld_o,
  output logic [PIPES*ADDR_W-1:0] pipe_addr_o,
  output logic [PIPES*TAG_W-1:0]  pipe_tag_o,
  output logic [CNT_W-1:0]        n_acc_o
);
  logic [LANES-1:0] take;

  always_comb begin
    int unsigned acc;
    logic        blocked;
    logic        clash;
    acc         = 0;
    blocked     = 1'b0;
    clash       = 1'b0;
    take        = '0;
    req_ready_o = '0;
    pipe_vld_o  = '0;
    pipe_addr_o = '0;
    pipe_tag_o  = '0;
    for (int k = 0; k < LANES; k++) begin
      clash = busy_hit_i[k];
      for (int j = 0; j < k; j++)
        if (take[j] && req_addr_i[j*ADDR_W +: ADDR_W] == req_addr_i[k*ADDR_W +: ADDR_W])
          clash = 1'b1;
      req_ready_o[k] = !blocked && (acc < PIPES) && ((32'(outst_i) + acc) < DEPTH) && !clash;
      take[k] = req_valid_i[k] && req_ready_o[k];
      if (take[k]) begin
        for (int unsigned p = 0; p < PIPES; p++) begin
          if (acc == p) begin
            pipe_vld_o[p]                    = 1'b1;
            pipe_addr_o[p*ADDR_W +: ADDR_W]  = req_addr_i[k*ADDR_W +: ADDR_W];
            pipe_tag_o[p*TAG_W +: TAG_W]     = req_tag_i[k*TAG_W +: TAG_W];
          end
        end
        acc = acc + 1;
      end else if (req_valid_i[k]) begin
        blocked = 1'b1;
      end
    end
    n_acc_o = CNT_W'(acc);
  end
endmodule

// File: rtl/apa_cplq.sv
module apa_cplq import apa_pkg::*; #(
  parameter int unsigned PIPES = 2,
  parameter int unsigned W     = 18,
  parameter int unsigned DEPTH = 8,
  parameter int unsigned CNT_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [PIPES-1:0]   push_i,
  input  logic [PIPES*W-1:0] push_data_i,
  input  logic               pop_i,
  output logic [W-1:0]       head_o,
  output logic [CNT_W-1:0]   count_o
);
  localparam int unsigned PTR_W = $clog2(DEPTH);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic [PTR_W-1:0] slot [PIPES];
  logic [CNT_W-1:0] n_push;

  // same-cycle pushes land in pipeline-index order
  always_comb begin
    int unsigned off;
    off = 0;
    for (int p = 0; p < PIPES; p++) begin
      slot[p] = PTR_W'(ring_idx(32'(wr_q), off, DEPTH));
      if (push_i[p]) off = off + 1;
    end
    n_push = CNT_W'(off);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= PTR_W'(ring_idx(32'(wr_q), 32'(n_push), DEPTH));
      if (pop_i) rd_q <= PTR_W'(ring_idx(32'(rd_q), 1, DEPTH));
      cnt_q <= cnt_q + n_push - CNT_W'(pop_i);
    end
  end

  always_ff @(posedge clk_i) begin
    for (int p = 0; p < PIPES; p++)
      if (push_i[p]) mem_q[slot[p]] <= push_data_i[p*W +: W];
  end

  assign head_o  = mem_q[rd_q];
  assign count_o = cnt_q;
endmodule

// File: rtl/atomic_pipe_alloc.sv
module atomic_pipe_alloc import apa_pkg::*; #(
  parameter int unsigned NUM_LANES  = DEF_LANES,
  parameter int unsigned NUM_PIPES  = DEF_PIPES,
  parameter int unsigned PIPE_LAT   = DEF_LAT,
  parameter int unsigned ADDR_W     = DEF_ADDR_W,
  parameter int unsigned TAG_W      = DEF_TAG_W,
  parameter int unsigned CPLQ_DEPTH = DEF_DEPTH
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NUM_LANES-1:0]        req_valid_i,
  output logic [NUM_LANES-1:0]        req_ready_o,
  input  logic [NUM_LANES*ADDR_W-1:0] req_addr_i,
  input  logic [NUM_LANES*TAG_W-1:0]  req_tag_i,
  output logic                        cpl_valid_o,
  output logic [ADDR_W-1:0]           cpl_addr_o,
  output logic [TAG_W-1:0]            cpl_tag_o
);
  localparam int unsigned CNT_W = $clog2(CPLQ_DEPTH + 1);
  localparam int unsigned ENT_W = ADDR_W + TAG_W;

  logic [CNT_W-1:0]              outst_q, n_acc, q_cnt;
  logic [NUM_LANES-1:0]          lane_hit;
  logic [NUM_LANES-1:0]          pipe_hit [NUM_PIPES];
  logic [NUM_PIPES-1:0]          pipe_vld;
  logic [NUM_PIPES*ADDR_W-1:0]   pipe_addr;
  logic [NUM_PIPES*TAG_W-1:0]    pipe_tag;
  logic [NUM_PIPES-1:0]          ret_vld;
  logic [ADDR_W-1:0]             ret_addr [NUM_PIPES];
  logic [TAG_W-1:0]              ret_tag  [NUM_PIPES];
  logic [NUM_PIPES*ENT_W-1:0]    ret_data;
  logic [NUM_PIPES*PIPE_LAT-1:0] stage_vld_all;
  logic [ENT_W-1:0]              cpl_data;

  apa_issue #(
    .LANES(NUM_LANES), .PIPES(NUM_PIPES), .ADDR_W(ADDR_W), .TAG_W(TAG_W),
    .DEPTH(CPLQ_DEPTH), .CNT_W(CNT_W)
  ) u_issue (
    .req_valid_i (req_valid_i),
    .req_addr_i  (req_addr_i),
    .req_tag_i   (req_tag_i),
    .busy_hit_i  (lane_hit),
    .outst_i     (outst_q),
    .req_ready_o (req_ready_o),
    .pipe_vld_o  (pipe_vld),
    .pipe_addr_o (pipe_addr),
    .pipe_tag_o  (pipe_tag),
    .n_acc_o     (n_acc)
  );

  for (genvar p = 0; p < NUM_PIPES; p++) begin : g_pipe
    apa_pipe #(
      .LAT(PIPE_LAT), .ADDR_W(ADDR_W), .TAG_W(TAG_W), .LANES(NUM_LANES)
    ) u_pipe (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .in_vld_i     (pipe_vld[p]),
      .in_addr_i    (pipe_addr[p*ADDR_W +: ADDR_W]),
      .in_tag_i     (pipe_tag[p*TAG_W +: TAG_W]),
      .probe_addr_i (req_addr_i),
      .probe_hit_o  (pipe_hit[p]),
      .stage_vld_o  (stage_vld_all[p*PIPE_LAT +: PIPE_LAT]),
      .ret_vld_o    (ret_vld[p]),
      .ret_addr_o   (ret_addr[p]),
      .ret_tag_o    (ret_tag[p])
    );
    assign ret_data[p*ENT_W +: ENT_W] = {ret_addr[p], ret_tag[p]};
  end

  always_comb begin
    lane_hit = '0;
    for (int p = 0; p < NUM_PIPES; p++) lane_hit = lane_hit | pipe_hit[p];
  end

  apa_cplq #(
    .PIPES(NUM_PIPES), .W(ENT_W), .DEPTH(CPLQ_DEPTH), .CNT_W(CNT_W)
  ) u_cplq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (ret_vld),
    .push_data_i (ret_data),
    .pop_i       (cpl_valid_o),
    .head_o      (cpl_data),
    .count_o     (q_cnt)
  );

  assign cpl_valid_o              = (q_cnt != '0);
  assign {cpl_addr_o, cpl_tag_o}  = cpl_data;

  // credits span pipelines plus queue, so the queue can never overflow
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) outst_q <= '0;
    else         outst_q <= outst_q + n_acc - CNT_W'(cpl_valid_o);
  end
endmodule

// File: rtl/apa_checker.sv
module apa_checker #(
  parameter int unsigned NUM_LANES  = 3,
  parameter int unsigned NUM_PIPES  = 2,
  parameter int unsigned PIPE_LAT   = 4,
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned CPLQ_DEPTH = 8,
  parameter int unsigned CNT_W      = 4
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic [NUM_LANES-1:0]          req_valid_i,
  input logic [NUM_LANES-1:0]          req_ready_i,
  input logic [NUM_LANES*ADDR_W-1:0]   req_addr_i,
  input logic [CNT_W-1:0]              outst_i,
  input logic [CNT_W-1:0]              q_cnt_i,
  input logic [NUM_PIPES*PIPE_LAT-1:0] stage_vld_i
);
  a_r2_pipe_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(req_valid_i & req_ready_i) <= NUM_PIPES);

  a_r8_credit_balance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(outst_i) == 32'(q_cnt_i) + $countones(stage_vld_i));

  a_r8_credit_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(outst_i) <= CPLQ_DEPTH);

  for (genvar k = 1; k < NUM_LANES; k++) begin : g_hi
    for (genvar j = 0; j < k; j++) begin : g_lo
      a_r3_lane_distinct: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i[j] && req_ready_i[j] && req_valid_i[k] && req_ready_i[k])
          |-> (req_addr_i[j*ADDR_W +: ADDR_W] != req_addr_i[k*ADDR_W +: ADDR_W]));
      a_r4_in_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i[j] && !req_ready_i[j]) |-> !req_ready_i[k]);
    end
  end
endmodule

bind atomic_pipe_alloc apa_checker #(
  .NUM_LANES(NUM_LANES), .NUM_PIPES(NUM_PIPES), .PIPE_LAT(PIPE_LAT),
  .ADDR_W(ADDR_W), .CPLQ_DEPTH(CPLQ_DEPTH), .CNT_W(CNT_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_i (req_ready_o),
  .req_addr_i  (req_addr_i),
  .outst_i     (outst_q),
  .q_cnt_i     (q_cnt),
  .stage_vld_i (stage_vld_all)
);

// File: tb/atomic_pipe_alloc_bench.sv
module atomic_pipe_alloc_bench;
  localparam int L = 3, NP = 2, LAT = 4, AW = 12, TW = 6, DEPTH = 8;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b1;
  logic [L-1:0]    req_valid_i = '0;
  logic [L-1:0]    req_ready_o;
  logic [L*AW-1:0] req_addr_i = '0;
  logic [L*TW-1:0] req_tag_i = '0;
  logic            cpl_valid_o;
  logic [AW-1:0]   cpl_addr_o;
  logic [TW-1:0]   cpl_tag_o;

  atomic_pipe_alloc #(
    .NUM_LANES(L), .NUM_PIPES(NP), .PIPE_LAT(LAT), .ADDR_W(AW), .TAG_W(TW), .CPLQ_DEPTH(DEPTH)
  ) u_atomic_pipe_alloc (.*);

  always #10 clk_i = ~clk_i;

  int n = 0;
  always @(posedge clk_i) if (rst_ni) n <= n + 1;

  int checks = 0, errors = 0;
  int exp_a[$], exp_t[$], exp_e[$];
  int hist_a[$], hist_e[$];
  logic [L-1:0] taken_last;
  int taken_n;
  logic saw_cpl;
  int saw_n;

  task automatic check(input logic ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic step(input logic [L-1:0] v, input logic [L*AW-1:0] a, input logic [L*TW-1:0] t);
    logic due, blk, clash;
    logic [L-1:0] er;
    int acc, outst, ak;
    @(negedge clk_i);
    due = (exp_e.size() > 0) && (exp_e[0] + LAT <= n);
    check(cpl_valid_o === due, "R6 completion valid timing", int'(cpl_valid_o), int'(due));
    if (cpl_valid_o === 1'b1) begin
      saw_cpl = 1'b1;
      saw_n   = n;
    end
    if (due && cpl_valid_o === 1'b1)
      check({cpl_addr_o, cpl_tag_o} === {exp_a[0][AW-1:0], exp_t[0][TW-1:0]},
            "R7 completion address and tag", int'({cpl_addr_o, cpl_tag_o}),
            int'({exp_a[0][AW-1:0], exp_t[0][TW-1:0]}));
    req_valid_i = v;
    req_addr_i  = a;
    req_tag_i   = t;
    #1;
    outst = exp_e.size();
    acc = 0;
    blk = 1'b0;
    er  = '0;
    for (int k = 0; k < L; k++) begin
      ak = int'(a[k*AW +: AW]);
      clash = 1'b0;
      for (int h = 0; h < hist_a.size(); h++)
        if (hist_a[h] == ak && hist_e[h] >= n - LAT + 2) clash = 1'b1;
      for (int j = 0; j < k; j++)
        if (v[j] && er[j] && int'(a[j*AW +: AW]) == ak) clash = 1'b1;
      er[k] = !blk && acc < NP && (outst + acc) < DEPTH && !clash;
      if (v[k] && er[k]) acc++;
      else if (v[k]) blk = 1'b1;
    end
    check(req_ready_o === er, "R2 R3 R4 R5 R8 ready vector", int'(req_ready_o), int'(er));
    if (due) begin
      void'(exp_a.pop_front());
      void'(exp_t.pop_front());
      void'(exp_e.pop_front());
    end
    for (int k = 0; k < L; k++) begin
      if (v[k] && er[k]) begin
        exp_a.push_back(int'(a[k*AW +: AW]));
        exp_t.push_back(int'(t[k*TW +: TW]));
        exp_e.push_back(n + 1);
        hist_a.push_back(int'(a[k*AW +: AW]));
        hist_e.push_back(n + 1);
      end
    end
    while (hist_e.size() > 0 && hist_e[0] + LAT < n) begin
      void'(hist_a.pop_front());
      void'(hist_e.pop_front());
    end
    taken_last = v & er;
    taken_n    = n;
  endtask

  task automatic idle(input int cnt);
    for (int i = 0; i < cnt; i++) step('0, '0, '0);
  endtask

  function automatic logic [L*AW-1:0] pack3(input int a0, input int a1, input int a2);
    return {AW'(a2), AW'(a1), AW'(a0)};
  endfunction

  initial begin
    int e0, fa;
    logic [L*AW-1:0] ra;
    logic [L*TW-1:0] rt;
    logic saw_zero;
    void'($urandom(32'h5EED));
    #1 rst_ni = 1'b0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;

    // R1 reset state
    #1;
    check(cpl_valid_o === 1'b0, "R1 no completion after reset", int'(cpl_valid_o), 0);
    check(req_ready_o === 3'b111, "R1 ready with no lanes valid", int'(req_ready_o), 7);
    step(3'b111, pack3(1, 2, 3), '0);
    check(req_ready_o === 3'b011, "R1 R2 lowest lanes fill the pipelines", int'(req_ready_o), 3);

    // R3 same-cycle duplicate line
    idle(DEPTH + LAT + 2);
    step(3'b011, pack3(5, 5, 0), '0);
    check(req_ready_o === 3'b001, "R3 duplicate lane blocked", int'(req_ready_o), 1);

    // R4 blocked head stops younger lanes
    step(3'b011, pack3(5, 6, 0), '0);
    check(req_ready_o === 3'b000, "R4 younger lanes wait behind head", int'(req_ready_o), 0);

    // R5 exact re-accept interval
    idle(DEPTH + LAT + 2);
    step(3'b001, pack3(9, 0, 0), 18'd1);
    check(taken_last[0] === 1'b1, "R5 first accept", int'(taken_last[0]), 1);
    e0 = taken_n + 1;
    for (int i = 0; i < 3 * LAT; i++) begin
      step(3'b001, pack3(9, 0, 0), 18'd1);
      if (taken_last[0]) break;
    end
    check(taken_n + 1 - e0 == LAT, "R5 re-accept interval", taken_n + 1 - e0, LAT);

    // R6 idle-path latency
    idle(DEPTH + LAT + 2);
    step(3'b001, pack3(10, 0, 0), 18'd2);
    e0 = taken_n + 1;
    saw_cpl = 1'b0;
    saw_n = -1;
    for (int i = 0; i < 3 * LAT; i++) begin
      step('0, '0, '0);
      if (saw_cpl) break;
    end
    check(saw_n == e0 + LAT, "R6 completion latency", saw_n, e0 + LAT);

    // R8 flood of distinct lines exhausts credits
    idle(DEPTH + LAT + 2);
    fa = 100;
    saw_zero = 1'b0;
    for (int i = 0; i < 40; i++) begin
      step(3'b111, pack3(fa, fa + 1, fa + 2), {6'(i), 6'(i + 1), 6'(i + 2)});
      if (req_ready_o === 3'b000) saw_zero = 1'b1;
      fa = fa + 3;
    end
    check(saw_zero === 1'b1, "R8 credit stall seen under flood", int'(saw_zero), 1);

    // random mix with a small address pool to provoke conflicts
    for (int i = 0; i < 3000; i++) begin
      for (int k = 0; k < L; k++) begin
        ra[k*AW +: AW] = AW'($urandom % 4);
        rt[k*TW +: TW] = TW'($urandom);
      end
      step(3'($urandom), ra, rt);
    end

    idle(DEPTH + LAT + 4);
    check(exp_e.size() == 0, "R6 R7 every accepted operation completed", exp_e.size(), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL R6 watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule